// File: doc/BRIEF.md
# Host Strobe-Framed Transmit FIFO Write Port

This block is the write side of a host bus slave. A host processor drives an asynchronous write cycle with an active-low chip select, an active-low write strobe, a small address field, a FIFO-select input and a 16-bit data word. The block runs on the local system clock and brings the cycle into that domain. It then sends the word either to the transmit data FIFO, as a one-cycle push with the data, or to the register space, as a one-cycle register-write pulse with the address and the data.

A write cycle exists only while both strobes are low. The cycle ends when either strobe goes high. The strobes may change in any order. Address, data and FIFO-select are captured in holding registers on the raw edge that ends the cycle. The host guarantees data setup only up to that edge, and no hold after it. The combined strobe passes through a multi-stage synchroniser. One pulse is made from each rising edge seen after the synchroniser.

When FIFO-select is high, the address is not decoded and the word always goes to the FIFO. If the FIFO reports full when the push would fire, the word is dropped and a sticky overrun flag is set. A dedicated input clears that flag. Each strobe level, high or low, is assumed to last at least `SYNC_STAGES` + 1 clock periods.

Top module: `host_wr_port`

## Requirements
- R1: After reset, the push pulse, the register-write pulse and the overrun flag are all low.
- R2: Each write cycle yields exactly one output pulse, and that pulse lasts one clock cycle.
- R3: No cycle is recognised while either strobe stays high. Toggling one strobe while the other is high produces no pulse of either kind.
- R4: The cycle begins when the last strobe falls and ends when the first strobe rises. Chip-select-first, write-first and simultaneous orderings, at both the assertion and the deassertion, each give one pulse.
- R5: The word delivered is the one on the data bus at the end of the cycle. Values present earlier in the cycle, or changed after it ends, are not used.
- R6: With FIFO-select high (1) at the end of the cycle, the word is pushed to the FIFO for every address value, and no register-write pulse is produced.
- R7: With FIFO-select low (0), a register-write pulse carries the captured address and data, and no push fires. The FIFO-full input does not affect register writes.
- R8: A FIFO-bound cycle that ends while FIFO-full is high produces no push, and the overrun flag is set on the next clock.
- R9: The overrun flag stays high until the clear input is sampled high. A new overrun in the same cycle as a clear wins over the clear.
- R10: The output pulse appears no later than `SYNC_STAGES` + 3 clock periods after the strobe that ends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Host chip select, active low |
| wrN | input | 1 | Host write strobe, active low |
| fifoSel | input | 1 | High: route the write to the transmit FIFO |
| addr | input | ADDR_W | Host address field |
| data | input | DATA_W | Host data bus |
| fifoFull | input | 1 | FIFO cannot accept a word |
| ovfClr | input | 1 | Clears the overrun flag |
| pushValid | output | 1 | One-cycle FIFO push pulse |
| pushData | output | DATA_W | Word that goes with the push |
| regWrValid | output | 1 | One-cycle register-write pulse |
| regWrAddr | output | ADDR_W | Address for the register write |
| regWrData | output | DATA_W | Data for the register write |
| overrun | output | 1 | Sticky: a word was dropped because the FIFO was full |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and `ADDR_W` = 5, and keeps `DATA_W` at 16. The deeper synchroniser makes the latency bound longer and so exercises it, and the bench measures each pulse against that bound. The 5-bit address lets the bench run a FIFO-select write at every address value. All nine combinations of assertion and deassertion order are driven, with the data bus changed both inside the cycle and right after it ends.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  // Control-to-datapath strobes, each one clock wide
  typedef struct packed {
    logic push;   // deliver captured word to the FIFO
    logic regWr;  // deliver captured word to the register space
    logic drop;   // FIFO-bound word lost, FIFO full
  } hwpStrobes_t;
endpackage

// File: rtl/hwp_ctrl.sv
module hwp_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  strobeN,
  input  logic                  capSel,
  input  logic                  fifoFull,
  output hwp_pkg::hwpStrobes_t  strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   endSeen;

  // Synchroniser chain, inactive (high) out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= strobeN;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= 1'b1;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[LAST];
  end

  assign endSeen = syncQ[LAST] & ~prevQ;

  always_comb begin
    strobes.push  = endSeen &  capSel & ~fifoFull;
    strobes.drop  = endSeen &  capSel &  fifoFull;
    strobes.regWr = endSeen & ~capSel;
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.push, strobes.regWr, strobes.drop}));

  // R2
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push || strobes.regWr || strobes.drop) |=>
      !(strobes.push || strobes.regWr || strobes.drop));
endmodule

// File: rtl/hwp_data.sv
module hwp_data #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  strobeN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  fifoSel,
  input  logic [DATA_W-1:0]     data,
  input  hwp_pkg::hwpStrobes_t  strobes,
  input  logic                  ovfClr,
  output logic                  capSel,
  output logic                  pushValid,
  output logic [DATA_W-1:0]     pushData,
  output logic                  regWrValid,
  output logic [ADDR_W-1:0]     regWrAddr,
  output logic [DATA_W-1:0]     regWrData,
  output logic                  overrun
);
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;

  // Holding registers: loaded on the raw end-of-cycle edge
  always_ff @(posedge strobeN or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
      capSel  <= 1'b0;
    end else begin
      capAddr <= addr;
      capData <= data;
      capSel  <= fifoSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pushValid  <= 1'b0;
      pushData   <= '0;
      regWrValid <= 1'b0;
      regWrAddr  <= '0;
      regWrData  <= '0;
    end else begin
      pushValid  <= strobes.push;
      regWrValid <= strobes.regWr;
      if (strobes.push) pushData <= capData;
      if (strobes.regWr) begin
        regWrAddr <= capAddr;
        regWrData <= capData;
      end
    end
  end

  // Sticky overrun, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             overrun <= 1'b0;
    else if (strobes.drop) overrun <= 1'b1;
    else if (ovfClr)       overrun <= 1'b0;
  end

  // R7
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pushValid && regWrValid));

  // R2
  push_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |=> !pushValid);

  // R8
  drop_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.drop |=> (overrun && !pushValid));

  // R9
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ovfClr) |=> overrun);

  // R9
  overrun_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr && !strobes.drop) |=> !overrun);
endmodule

// File: rtl/host_wr_port.sv
module host_wr_port #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              fifoSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              fifoFull,
  input  logic              ovfClr,
  output logic              pushValid,
  output logic [DATA_W-1:0] pushData,
  output logic              regWrValid,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              overrun
);
  hwp_pkg::hwpStrobes_t strobes;
  logic strobeN;
  logic capSel;

  // Cycle is active only while both strobes are low
  assign strobeN = csN | wrN;

  hwp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strobeN  (strobeN),
    .capSel   (capSel),
    .fifoFull (fifoFull),
    .strobes  (strobes)
  );

  hwp_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobeN    (strobeN),
    .addr       (addr),
    .fifoSel    (fifoSel),
    .data       (data),
    .strobes    (strobes),
    .ovfClr     (ovfClr),
    .capSel     (capSel),
    .pushValid  (pushValid),
    .pushData   (pushData),
    .regWrValid (regWrValid),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .overrun    (overrun)
  );
endmodule

// File: tb/test_host_wr_port.sv
`timescale 1ns/1ps
module test_host_wr_port;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int SS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, fifoSel = 1'b0, fifoFull = 1'b0, ovfClr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic pushValid, regWrValid, overrun;
  logic [DW-1:0] pushData, regWrData;
  logic [AW-1:0] regWrAddr;

  int checks = 0, fails = 0;
  int pushCnt = 0, regCnt = 0;
  logic [DW-1:0] lastPush = '0, lastRegData = '0;
  logic [AW-1:0] lastRegAddr = '0;
  realtime endTime = 0, pulseTime = 0;

  always #4 clk = ~clk;

  host_wr_port #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SS)) i_host_wr_port (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .fifoSel(fifoSel),
    .addr(addr), .data(data), .fifoFull(fifoFull), .ovfClr(ovfClr),
    .pushValid(pushValid), .pushData(pushData), .regWrValid(regWrValid),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .overrun(overrun)
  );

  always @(negedge clk) begin
    if (pushValid === 1'b1) begin
      pushCnt++; lastPush = pushData; pulseTime = $realtime;
    end
    if (regWrValid === 1'b1) begin
      regCnt++; lastRegAddr = regWrAddr; lastRegData = regWrData; pulseTime = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ord: 0 chip select first, 1 write first, 2 together
  task automatic hostWrite(input int aOrd, input int dOrd, input logic sel,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; fifoSel = sel; data = ~d;
    case (aOrd)
      0: begin csN = 1'b0; #6; wrN = 1'b0; end
      1: begin wrN = 1'b0; #6; csN = 1'b0; end
      default: begin csN = 1'b0; wrN = 1'b0; end
    endcase
    #20; data = d; #20;
    case (dOrd)
      0: begin csN = 1'b1; endTime = $realtime; #1; data = d ^ 16'h5a5a; addr = ~a; fifoSel = ~sel; #5; wrN = 1'b1; end
      1: begin wrN = 1'b1; endTime = $realtime; #1; data = d ^ 16'h5a5a; addr = ~a; fifoSel = ~sel; #5; csN = 1'b1; end
      default: begin csN = 1'b1; wrN = 1'b1; endTime = $realtime; #1; data = d ^ 16'h5a5a; addr = ~a; fifoSel = ~sel; end
    endcase
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    check(pushValid == 1'b0, "R1 pushValid", pushValid, 0);
    check(regWrValid == 1'b0, "R1 regWrValid", regWrValid, 0);
    check(overrun == 1'b0, "R1 overrun", overrun, 0);
  endtask

  task automatic testOrders();
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        int p0 = pushCnt;
        logic [DW-1:0] w = DW'(16'h1000 + a * 16 + b);
        hostWrite(a, b, 1'b1, AW'(a + b), w);
        check(pushCnt == p0 + 1, "R4 R2 one push per cycle", pushCnt - p0, 1);
        check(lastPush == w, "R5 word at cycle end", lastPush, w);
        check(pulseTime - endTime <= (SS + 3) * 8.0, "R10 latency",
              longint'(pulseTime - endTime), (SS + 3) * 8);
      end
    end
  endtask

  task automatic testFraming();
    int p0 = pushCnt, r0 = regCnt;
    fifoSel = 1'b1;
    for (int i = 0; i < 3; i++) begin
      wrN = 1'b0; #60; wrN = 1'b1; #60;
    end
    fifoSel = 1'b0;
    for (int i = 0; i < 3; i++) begin
      csN = 1'b0; #60; csN = 1'b1; #60;
    end
    repeat (12) @(posedge clk);
    #1;
    check(pushCnt == p0, "R3 no push on single strobe", pushCnt - p0, 0);
    check(regCnt == r0, "R3 no reg write on single strobe", regCnt - r0, 0);
  endtask

  task automatic testAddrIgnore();
    int bad = 0;
    int r0 = regCnt;
    for (int a = 0; a < (1 << AW); a++) begin
      int p0 = pushCnt;
      logic [DW-1:0] w = DW'(16'hc000 | a);
      hostWrite(a % 3, 2, 1'b1, AW'(a), w);
      if (pushCnt != p0 + 1 || lastPush != w) bad++;
    end
    check(bad == 0, "R6 push for every address", bad, 0);
    check(regCnt == r0, "R6 no reg write when selected", regCnt - r0, 0);
  endtask

  task automatic testRegWrite();
    int p0 = pushCnt, r0 = regCnt;
    fifoFull = 1'b1;
    hostWrite(1, 0, 1'b0, 5'h13, 16'hbeef);
    fifoFull = 1'b0;
    check(regCnt == r0 + 1, "R7 one reg write", regCnt - r0, 1);
    check(lastRegAddr == 5'h13, "R7 reg address", lastRegAddr, 5'h13);
    check(lastRegData == 16'hbeef, "R7 reg data", lastRegData, 16'hbeef);
    check(pushCnt == p0, "R7 no push", pushCnt - p0, 0);
    check(overrun == 1'b0, "R7 full ignored for reg write", overrun, 0);
  endtask

  task automatic testOverrun();
    int p0 = pushCnt;
    fifoFull = 1'b1;
    hostWrite(0, 1, 1'b1, 5'h02, 16'h7777);
    fifoFull = 1'b0;
    check(pushCnt == p0, "R8 word dropped", pushCnt - p0, 0);
    check(overrun == 1'b1, "R8 overrun set", overrun, 1);
    hostWrite(2, 0, 1'b1, 5'h03, 16'h8888);
    check(pushCnt == p0 + 1, "R9 push after full clears", pushCnt - p0, 1);
    check(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;
    @(negedge clk);
    check(overrun == 1'b0, "R9 overrun cleared", overrun, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    testOrders();
    testFraming();
    testAddrIgnore();
    testRegWrite();
    testOverrun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule